// File: doc/BRIEF.md
# Decimal Shaft-Angle Up/Down Counter

This block keeps a shaft angle as a decimal-coded count with a resolution of one tenth of a degree. A tracking loop upstream sends one-step requests to raise or lower the angle. Each clock cycle the block accepts at most one net step. It presents the angle on parallel decimal digit outputs. It also raises a busy strobe of fixed length for every step it accepts. Downstream logic reads the digits once the strobe has ended.

The parameter `SIGNED_MODE` selects one of two output formats. With `SIGNED_MODE` = 0 the angle runs from 0.0 to 359.9. With `SIGNED_MODE` = 1 it is a sign and a magnitude, from -180.0 up to +179.9. Both formats wrap around.

An active-low hold input freezes the digit outputs so that a reader can copy them safely. While the hold is applied, the internal count keeps following the step requests and the busy strobe keeps pulsing. When the hold is released, the outputs show the live count at once.

Top module: `angle_bcd_counter`

## Requirements
- R1: After reset, all digit outputs are zero, the angle is +0.0 and `busy` is low. At all times `ang_tenths`, `ang_units` and `ang_tens` each hold a BCD digit from 0 to 9. The hundreds value is carried by two bits: `ang_h100` has weight 100 degrees and `ang_h200` has weight 200 degrees. With `SIGNED_MODE` = 0, `ang_neg` stays 0 and the value never exceeds 359.9. With `SIGNED_MODE` = 1, `ang_h200` stays 0.
- R2: A cycle with `up_req` = 1 and `dn_req` = 0 raises the angle by 0.1 degree, with decimal carries. For example 9.9 becomes 10.0 and 199.9 becomes 200.0.
- R3: A cycle with `dn_req` = 1 and `up_req` = 0 lowers the angle by 0.1 degree, with decimal borrows. For example 100.0 becomes 99.9.
- R4: With `SIGNED_MODE` = 0, a step up from 359.9 gives 0.0, and a step down from 0.0 gives 359.9.
- R5: With `SIGNED_MODE` = 1, `ang_neg` = 0 means a positive angle and `ang_neg` = 1 means a negative one. The value moves by 0.1 degree per step across the sign boundary: a step up from +179.9 gives -180.0, a step up from -0.1 gives +0.0, a step down from +0.0 gives -0.1, and a step down from -180.0 gives +179.9.
- R6: A cycle with both requests high, or with both low, leaves the count unchanged and starts no busy pulse.
- R7: Each accepted step drives `busy` high for exactly `BUSY_CYCLES` cycles. The pulse starts right after the clock edge that accepts the step. A step accepted while `busy` is high restarts the full width.
- R8: The new angle appears on the outputs after the same clock edge that accepts the step, in the same cycle that `busy` rises.
- R9: While `inhibit_n` is low, the digit and sign outputs keep their value. Meanwhile the internal count still follows the step requests, and `busy` still pulses for each step.
- R10: When `inhibit_n` returns high, the outputs show the current internal count at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | One-cycle request to step up by 0.1 degree |
| dn_req | input | 1 | One-cycle request to step down by 0.1 degree |
| inhibit_n | input | 1 | Active-low hold of the digit outputs |
| ang_tenths | output | 4 | BCD digit, weight 0.1 degree |
| ang_units | output | 4 | BCD digit, weight 1 degree |
| ang_tens | output | 4 | BCD digit, weight 10 degrees |
| ang_h100 | output | 1 | Hundreds bit, weight 100 degrees |
| ang_h200 | output | 1 | Hundreds bit, weight 200 degrees (unsigned format only) |
| ang_neg | output | 1 | Sign, 1 means negative (signed format only) |
| busy | output | 1 | High for `BUSY_CYCLES` cycles after each accepted step |

## Verification
The bench builds two copies of the block and feeds both the same request stream. One copy uses the unsigned format with a busy width of 3 cycles. The other uses the signed format with a width of 5 cycles. Because the widths differ, a single stream exercises both the pulse restart and the clean end of a pulse. Runs of several thousand steps take both copies around a full turn in each direction. This reaches every decimal carry and borrow, the 359.9/0.0 wrap, and all four crossings at the sign boundary.

// File: rtl/angle_bcd_pkg.sv
`timescale 1ns/1ps
package angle_bcd_pkg;

  // One tracked angle in decimal digits; hund holds the 100/200 degree bits.
  typedef struct packed {
    logic [1:0] hund;
    logic [3:0] tens;
    logic [3:0] units;
    logic [3:0] tenths;
  } bcd_ang_t;

  typedef struct packed {
    logic     neg;
    bcd_ang_t mag;
  } angle_t;

  localparam bcd_ang_t ANG_ZERO  = {2'd0, 4'd0, 4'd0, 4'd0};
  localparam bcd_ang_t ANG_TENTH = {2'd0, 4'd0, 4'd0, 4'd1};
  localparam bcd_ang_t U_TOP     = {2'd3, 4'd5, 4'd9, 4'd9};  // 359.9
  localparam bcd_ang_t S_TOP     = {2'd1, 4'd7, 4'd9, 4'd9};  // 179.9
  localparam bcd_ang_t S_BOTTOM  = {2'd1, 4'd8, 4'd0, 4'd0};  // 180.0 magnitude

  function automatic logic [3:0] dig_up(input logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic [3:0] dig_dn(input logic [3:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction

  // Add one tenth with decimal carry through the digit chain.
  function automatic bcd_ang_t bcd_inc(input bcd_ang_t a);
    bcd_ang_t r;
    r = a;
    r.tenths = dig_up(a.tenths);
    if (a.tenths == 4'd9) begin
      r.units = dig_up(a.units);
      if (a.units == 4'd9) begin
        r.tens = dig_up(a.tens);
        if (a.tens == 4'd9) r.hund = a.hund + 2'd1;
      end
    end
    return r;
  endfunction

  // Remove one tenth with decimal borrow through the digit chain.
  function automatic bcd_ang_t bcd_dec(input bcd_ang_t a);
    bcd_ang_t r;
    r = a;
    r.tenths = dig_dn(a.tenths);
    if (a.tenths == 4'd0) begin
      r.units = dig_dn(a.units);
      if (a.units == 4'd0) begin
        r.tens = dig_dn(a.tens);
        if (a.tens == 4'd0) r.hund = a.hund - 2'd1;
      end
    end
    return r;
  endfunction

  // Full-turn format: 0.0 .. 359.9, wrapping both ways.
  function automatic angle_t step_full_turn(input angle_t a, input logic up);
    angle_t r;
    r.neg = 1'b0;
    if (up) r.mag = (a.mag == U_TOP) ? ANG_ZERO : bcd_inc(a.mag);
    else    r.mag = (a.mag == ANG_ZERO) ? U_TOP : bcd_dec(a.mag);
    return r;
  endfunction

  // Sign-magnitude format: -180.0 .. +179.9, wrapping both ways.
  function automatic angle_t step_half_turn(input angle_t a, input logic up);
    angle_t r;
    r = a;
    if (up) begin
      if (!a.neg) begin
        if (a.mag == S_TOP) begin r.neg = 1'b1; r.mag = S_BOTTOM; end
        else r.mag = bcd_inc(a.mag);
      end else begin
        if (a.mag == ANG_TENTH) begin r.neg = 1'b0; r.mag = ANG_ZERO; end
        else r.mag = bcd_dec(a.mag);
      end
    end else begin
      if (!a.neg) begin
        if (a.mag == ANG_ZERO) begin r.neg = 1'b1; r.mag = ANG_TENTH; end
        else r.mag = bcd_dec(a.mag);
      end else begin
        if (a.mag == S_BOTTOM) begin r.neg = 1'b0; r.mag = S_TOP; end
        else r.mag = bcd_inc(a.mag);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/bcd_angle_core.sv
`timescale 1ns/1ps
module bcd_angle_core
  import angle_bcd_pkg::*;
#(
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   up_req,
  input  logic   dn_req,
  output logic   step_evt,
  output angle_t live_q,
  output angle_t live_next
);

  angle_t stepped;

  assign step_evt = up_req ^ dn_req;

  generate
    if (SIGNED_MODE) begin : g_half
      assign stepped = step_half_turn(live_q, up_req);
    end else begin : g_full
      assign stepped = step_full_turn(live_q, up_req);
    end
  endgenerate

  assign live_next = step_evt ? stepped : live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_next;
  end

endmodule

// File: rtl/busy_pulse_gen.sv
`timescale 1ns/1ps
module busy_pulse_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIDTH);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               left_q <= '0;
    else if (trig)            left_q <= LOAD;
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/angle_out_hold.sv
`timescale 1ns/1ps
module angle_out_hold
  import angle_bcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   inhibit_n,
  input  angle_t live_q,
  input  angle_t live_next,
  output angle_t shown
);

  angle_t held_q;

  // Track the value the count takes at each edge while not held.
  always_ff @(posedge clk) begin
    if (!rst_n)         held_q <= '0;
    else if (inhibit_n) held_q <= live_next;
  end

  assign shown = inhibit_n ? live_q : held_q;

endmodule

// File: rtl/angle_bcd_counter.sv
`timescale 1ns/1ps
module angle_bcd_counter
  import angle_bcd_pkg::*;
#(
  parameter bit          SIGNED_MODE = 1'b0,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_req,
  input  logic       dn_req,
  input  logic       inhibit_n,
  output logic [3:0] ang_tenths,
  output logic [3:0] ang_units,
  output logic [3:0] ang_tens,
  output logic       ang_h100,
  output logic       ang_h200,
  output logic       ang_neg,
  output logic       busy
);

  logic   step_evt;
  angle_t live_q;
  angle_t live_next;
  angle_t shown;

  bcd_angle_core #(.SIGNED_MODE(SIGNED_MODE)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_req    (up_req),
    .dn_req    (dn_req),
    .step_evt  (step_evt),
    .live_q    (live_q),
    .live_next (live_next)
  );

  busy_pulse_gen #(.WIDTH(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (step_evt),
    .busy  (busy)
  );

  angle_out_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .inhibit_n (inhibit_n),
    .live_q    (live_q),
    .live_next (live_next),
    .shown     (shown)
  );

  assign ang_tenths = shown.mag.tenths;
  assign ang_units  = shown.mag.units;
  assign ang_tens   = shown.mag.tens;
  assign ang_h100   = shown.mag.hund[0];
  assign ang_h200   = shown.mag.hund[1];
  assign ang_neg    = shown.neg;

endmodule

// File: rtl/angle_bcd_counter_chk.sv
`timescale 1ns/1ps
module angle_bcd_counter_chk
  import angle_bcd_pkg::*;
#(
  parameter bit          SIGNED_MODE = 1'b0,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input logic   clk,
  input logic   rst_n,
  input logic   up_req,
  input logic   dn_req,
  input logic   inhibit_n,
  input logic   step_evt,
  input angle_t live_q,
  input angle_t shown,
  input logic   busy
);

  localparam int SW = $clog2(BUSY_CYCLES + 2);
  localparam logic [SW-1:0] IDLE_MARK = SW'(BUSY_CYCLES + 1);
  localparam logic [SW-1:0] LIMIT     = SW'(BUSY_CYCLES);

  // Cycles since the last accepted step, saturating.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                   since_q <= IDLE_MARK;
    else if (step_evt)            since_q <= '0;
    else if (since_q != IDLE_MARK) since_q <= since_q + 1'b1;
  end

  assert_digits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live_q.mag.tenths <= 4'd9 && live_q.mag.units <= 4'd9 && live_q.mag.tens <= 4'd9);

  generate
    if (SIGNED_MODE) begin : g_rng_s
      assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q.mag.hund <= 2'd1 &&
        !(live_q.mag.hund == 2'd1 && live_q.mag.tens > 4'd8) &&
        !(live_q.mag.hund == 2'd1 && live_q.mag.tens == 4'd8 &&
          (live_q.mag.units != 4'd0 || live_q.mag.tenths != 4'd0 || !live_q.neg)));
    end else begin : g_rng_u
      assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q.neg && !(live_q.mag.hund == 2'd3 && live_q.mag.tens > 4'd5));
    end
  endgenerate

  assert_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_req ^ dn_req) |=> $stable(live_q));

  assert_step_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req ^ dn_req) |=> !$stable(live_q));

  assert_busy_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> busy);

  assert_busy_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (since_q < LIMIT));

  assert_inhibit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit_n && !$past(inhibit_n)) |-> $stable(shown));

  assert_release_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_n |-> (shown == live_q));

endmodule

bind angle_bcd_counter angle_bcd_counter_chk #(
  .SIGNED_MODE (SIGNED_MODE),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .up_req    (up_req),
  .dn_req    (dn_req),
  .inhibit_n (inhibit_n),
  .step_evt  (step_evt),
  .live_q    (live_q),
  .shown     (shown),
  .busy      (busy)
);

// File: tb/angle_bcd_counter_tb.sv
`timescale 1ns/1ps
module angle_bcd_counter_tb;

  localparam int WU = 3;
  localparam int WS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0;
  logic dn_req = 1'b0;
  logic inhibit_n = 1'b1;

  always #2.5 clk = ~clk;

  logic [3:0] u_t, u_u, u_te, s_t, s_u, s_te;
  logic u_h1, u_h2, u_n, u_b, s_h1, s_h2, s_n, s_b;

  angle_bcd_counter #(.SIGNED_MODE(1'b0), .BUSY_CYCLES(WU)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req), .inhibit_n(inhibit_n),
    .ang_tenths(u_t), .ang_units(u_u), .ang_tens(u_te), .ang_h100(u_h1),
    .ang_h200(u_h2), .ang_neg(u_n), .busy(u_b));

  angle_bcd_counter #(.SIGNED_MODE(1'b1), .BUSY_CYCLES(WS)) u_dut_sgn (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req), .inhibit_n(inhibit_n),
    .ang_tenths(s_t), .ang_units(s_u), .ang_tens(s_te), .ang_h100(s_h1),
    .ang_h200(s_h2), .ang_neg(s_n), .busy(s_b));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model in tenths of a degree.
  int uv = 0, sv = 0, u_held = 0, s_held = 0, bu = 0, bs = 0;
  bit inh_prev = 1'b1;

  typedef struct {
    int    ue;
    int    se;
    bit    ub;
    bit    sb;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  function automatic logic [14:0] pack_ref(input int v);
    int m, h;
    logic neg;
    neg = (v < 0);
    m = neg ? -v : v;
    h = m / 1000;
    return {neg, 1'((h >> 1) & 1), 1'(h & 1), 4'((m / 100) % 10),
            4'((m / 10) % 10), 4'(m % 10)};
  endfunction

  function automatic logic [14:0] u_got();
    return {u_n, u_h2, u_h1, u_te, u_u, u_t};
  endfunction

  function automatic logic [14:0] s_got();
    return {s_n, s_h2, s_h1, s_te, s_u, s_t};
  endfunction

  task automatic chk(input string tag, input string what, input logic [14:0] got,
                     input logic [14:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outputs.
  task automatic cycle(input bit up, input bit dn, input bit inh, input string tag);
    exp_t it;
    @(negedge clk);
    up_req = up;
    dn_req = dn;
    inhibit_n = inh;
    if (inh && !inh_prev) begin
      #1;
      chk({tag, " R10"}, "unsigned release", u_got(), pack_ref(uv));
      chk({tag, " R10"}, "signed release", s_got(), pack_ref(sv));
    end
    inh_prev = inh;
    if (up != dn) begin
      if (up) begin
        uv = (uv + 1) % 3600;
        sv = (sv == 1799) ? -1800 : sv + 1;
      end else begin
        uv = (uv + 3599) % 3600;
        sv = (sv == -1800) ? 1799 : sv - 1;
      end
      bu = WU;
      bs = WS;
    end else begin
      if (bu > 0) bu--;
      if (bs > 0) bs--;
    end
    if (inh) begin
      u_held = uv;
      s_held = sv;
    end
    it.ue = inh ? uv : u_held;
    it.se = inh ? sv : s_held;
    it.ub = (bu > 0);
    it.sb = (bs > 0);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: after each edge, compare everything the driver queued.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        chk(it.tag, "unsigned angle", u_got(), pack_ref(it.ue));
        chk(it.tag, "signed angle", s_got(), pack_ref(it.se));
        chk({it.tag, " R7"}, "unsigned busy", 15'(u_b), 15'(it.ub));
        chk({it.tag, " R7"}, "signed busy", 15'(s_b), 15'(it.sb));
      end
    end
  end

  initial begin
    #(500_000ns);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset", "unsigned angle", u_got(), 15'd0);
    chk("R1 reset", "signed angle", s_got(), 15'd0);
    chk("R1 reset", "busy pair", {13'd0, u_b, s_b}, 15'd0);

    for (int i = 0; i < 105; i++) cycle(1, 0, 1, "R2 R8 carry into units and tens");
    for (int i = 0; i < 7; i++)   cycle(0, 0, 1, "R7 pulse ends");
    cycle(1, 0, 1, "R7 restart");
    cycle(0, 0, 1, "R7 restart");
    cycle(1, 0, 1, "R7 restart");
    for (int i = 0; i < 7; i++)   cycle(0, 0, 1, "R7 restart");
    for (int i = 0; i < 1895; i++) cycle(1, 0, 1, "R2 R5 hundreds carry, +179.9 to -180.0");
    for (int i = 0; i < 1600; i++) cycle(1, 0, 1, "R4 R5 wrap upward");
    for (int i = 0; i < 10; i++)   cycle(0, 1, 1, "R3 R4 R5 wrap downward");
    for (int i = 0; i < 4; i++)    cycle(1, 1, 1, "R6 both requests");
    for (int i = 0; i < 6; i++)    cycle(0, 0, 1, "R6 no request");
    for (int i = 0; i < 25; i++)   cycle(1, 0, 0, "R9 held while stepping");
    for (int i = 0; i < 3; i++)    cycle(0, 0, 0, "R9 held idle");
    cycle(0, 0, 1, "R10 release");
    for (int i = 0; i < 4; i++)    cycle(0, 0, 1, "R10 after release");
    for (int i = 0; i < 3700; i++) cycle(0, 1, 1, "R3 R4 R5 long borrow run");
    for (int i = 0; i < 8; i++)    cycle(0, 0, 1, "R6 R7 settle");

    @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule